// File: doc/BRIEF.md
# Periodic Tick Timer with 64-bit Comparator

This block is a free-running 64-bit up-counter paired with a 64-bit compare register. Together they produce periodic system ticks. A small 32-bit word bus reaches seven registers: control, the two counter halves, the two compare halves, a step (period) register and a status register. Reads are combinational and always show live contents. The counter halves are not latched together. Software that needs a consistent 64-bit value reads the upper half, then the lower half, then the upper half again, and retries if the two upper reads differ.

A compare event happens when comparison is enabled, the comparator is armed, and the count is at or above the compare value. Each event sets a sticky pending flag. If interrupts are enabled, the event also gives a one-cycle pulse on the interrupt output. In step mode the event adds the step value to the compare value, so the next tick lands exactly one period later and no drift builds up.

The comparator is a three-state machine:
- **CMP_OFF**: comparison is disabled.
- **CMP_ARMED**: the comparator may fire.
- **CMP_HIT**: it has fired once outside step mode and now waits.

Its transitions are:
- **disable**: any state goes to CMP_OFF when compare-enable is clear.
- **arm**: CMP_OFF goes to CMP_ARMED when compare-enable is set.
- **fire-once**: CMP_ARMED goes to CMP_HIT on an event with step mode off.
- **rearm**: any state goes to CMP_ARMED on a write to either compare half while compare-enable is set.

In step mode an event keeps the machine in CMP_ARMED.

Top module: `global_tick_timer`

## Requirements
- R1: After reset every register reads zero and the interrupt output is low.
- R2: While control bit 0 (run) is set, the counter rises by exactly one per clock. The carry passes from the low word into the high word. While run is clear, the counter holds.
- R3: Word address 1 reads the low 32 bits of the live counter and address 2 reads the high 32 bits. Writes to them load that half only while run is clear; while run is set they are ignored.
- R4: Control is at address 0, with bit 0 run, bit 1 compare-enable, bit 2 interrupt-enable and bit 3 step mode. It reads back these four bits, and bits 31:4 read zero.
- R5: A compare event occurs in a cycle when compare-enable is set, the comparator is armed, and count >= compare (addresses 3 low, 4 high). The event sets bit 0 of status (address 6).
- R6: The interrupt output is high for exactly the one cycle after each compare event, and only if interrupt-enable was set in the event cycle.
- R7: In step mode each event adds the step register (address 5, zero-extended) to the compare value, and the comparator stays armed.
- R8: Outside step mode, at most one event occurs per arming. The comparator re-arms one cycle after compare-enable goes from clear to set, or on any compare-half write while compare-enable is set.
- R9: Writing status with bit 0 = 1 clears the pending flag, and writing 0 leaves it alone. If an event falls in the same cycle as a clear, the flag stays set.
- R10: With compare-enable clear, no event occurs. A bus write to a compare half takes priority over a step addition in the same cycle. Address 7 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| tick_irq | output | 1 | One-cycle interrupt pulse |

## Verification
Two pairs of functions can meet in one clock.

The first pair is a compare event and a status clear. The bench sets step mode with a step of zero so that an event fires every cycle, then writes 1 to status. The flag must still read set, while a later clear with comparison off must take effect.

The second pair is a step addition and a compare write. In the random phase, compare writes often land while the comparator fires in step mode. The bench's reference model lets the bus value win, and every read and interrupt cycle is compared against that model.

// File: rtl/gtt_pkg.sv
package gtt_pkg;

    typedef enum logic [2:0] {
        REG_CTRL   = 3'd0,
        REG_CNT_LO = 3'd1,
        REG_CNT_HI = 3'd2,
        REG_CMP_LO = 3'd3,
        REG_CMP_HI = 3'd4,
        REG_STEP   = 3'd5,
        REG_STATUS = 3'd6,
        REG_NONE   = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        CMP_OFF   = 2'd0,
        CMP_ARMED = 2'd1,
        CMP_HIT   = 2'd2
    } cmp_state_e;

    // bit 3 step_on, bit 2 irq_on, bit 1 cmp_on, bit 0 run
    typedef struct packed {
        logic step_on;
        logic irq_on;
        logic cmp_on;
        logic run;
    } ctrl_t;

    localparam int CTRL_W = 4;

endpackage

// File: rtl/gtt_regs.sv
module gtt_regs
    import gtt_pkg::*;
#(
    parameter int BUS_W = 32,
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_en,
    input  logic             bus_we,
    input  logic [2:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             cmp_event,
    output ctrl_t            ctrl,
    output logic [BUS_W-1:0] step,
    output logic             pending,
    output logic             wr_cnt_lo,
    output logic             wr_cnt_hi,
    output logic             wr_cmp_lo,
    output logic             wr_cmp_hi,
    output logic             st_clr,
    output logic [BUS_W-1:0] bus_rdata
);

    localparam int PAD_W = BUS_W - CTRL_W;

    reg_sel_e sel;
    logic     wr;

    assign sel = reg_sel_e'(bus_addr);
    assign wr  = bus_en && bus_we;

    assign wr_cnt_lo = wr && (sel == REG_CNT_LO) && !ctrl.run;
    assign wr_cnt_hi = wr && (sel == REG_CNT_HI) && !ctrl.run;
    assign wr_cmp_lo = wr && (sel == REG_CMP_LO);
    assign wr_cmp_hi = wr && (sel == REG_CMP_HI);
    assign st_clr    = wr && (sel == REG_STATUS) && bus_wdata[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr && sel == REG_CTRL) begin
            ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= '0;
        end else if (wr && sel == REG_STEP) begin
            step <= bus_wdata;
        end
    end

    // event has priority over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (cmp_event) begin
            pending <= 1'b1;
        end else if (st_clr) begin
            pending <= 1'b0;
        end
    end

    always_comb begin
        unique case (sel)
            REG_CTRL:   bus_rdata = {{PAD_W{1'b0}}, ctrl};
            REG_CNT_LO: bus_rdata = count[BUS_W-1:0];
            REG_CNT_HI: bus_rdata = count[CNT_W-1:BUS_W];
            REG_CMP_LO: bus_rdata = cmp_val[BUS_W-1:0];
            REG_CMP_HI: bus_rdata = cmp_val[CNT_W-1:BUS_W];
            REG_STEP:   bus_rdata = step;
            REG_STATUS: bus_rdata = {{(BUS_W-1){1'b0}}, pending};
            REG_NONE:   bus_rdata = '0;
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gtt_counter.sv
module gtt_counter #(
    parameter int BUS_W = 32,
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [BUS_W-1:0] wdata,
    output logic [CNT_W-1:0] count
);

    localparam int HI_W = CNT_W - BUS_W;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wr_lo) begin
            count[BUS_W-1:0] <= wdata;
        end else if (wr_hi) begin
            count[CNT_W-1:BUS_W] <= wdata[HI_W-1:0];
        end else if (run) begin
            count <= count + {{(CNT_W-1){1'b0}}, 1'b1};
        end
    end

endmodule

// File: rtl/gtt_compare.sv
module gtt_compare
    import gtt_pkg::*;
#(
    parameter int BUS_W = 32,
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] count,
    input  logic [BUS_W-1:0] step,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [BUS_W-1:0] wdata,
    output logic [CNT_W-1:0] cmp_val,
    output logic             cmp_event,
    output logic             irq
);

    localparam int HI_W  = CNT_W - BUS_W;
    localparam int EXT_W = CNT_W - BUS_W;

    cmp_state_e state, state_nxt;
    logic       cmp_wr;

    assign cmp_wr    = wr_lo || wr_hi;
    assign cmp_event = (state == CMP_ARMED) && ctrl.cmp_on && (count >= cmp_val);

    always_comb begin
        state_nxt = state;
        if (!ctrl.cmp_on) begin
            state_nxt = CMP_OFF;
        end else if (cmp_wr) begin
            state_nxt = CMP_ARMED;
        end else begin
            unique case (state)
                CMP_OFF:   state_nxt = CMP_ARMED;
                CMP_ARMED: state_nxt = (cmp_event && !ctrl.step_on) ? CMP_HIT : CMP_ARMED;
                CMP_HIT:   state_nxt = CMP_HIT;
                default:   state_nxt = CMP_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CMP_OFF;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= cmp_event && ctrl.irq_on;
        end
    end

    // bus write wins over the step addition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_val <= '0;
        end else if (wr_lo) begin
            cmp_val[BUS_W-1:0] <= wdata;
        end else if (wr_hi) begin
            cmp_val[CNT_W-1:BUS_W] <= wdata[HI_W-1:0];
        end else if (cmp_event && ctrl.step_on) begin
            cmp_val <= cmp_val + {{EXT_W{1'b0}}, step};
        end
    end

endmodule

// File: rtl/global_tick_timer.sv
module global_tick_timer
    import gtt_pkg::*;
#(
    parameter int BUS_W = 32,
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_en,
    input  logic             bus_we,
    input  logic [2:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             tick_irq
);

    ctrl_t            ctrl;
    logic [BUS_W-1:0] step;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] cmp_val;
    logic             pending;
    logic             cmp_event;
    logic             wr_cnt_lo, wr_cnt_hi, wr_cmp_lo, wr_cmp_hi, st_clr;

    gtt_regs #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .count     (count),
        .cmp_val   (cmp_val),
        .cmp_event (cmp_event),
        .ctrl      (ctrl),
        .step      (step),
        .pending   (pending),
        .wr_cnt_lo (wr_cnt_lo),
        .wr_cnt_hi (wr_cnt_hi),
        .wr_cmp_lo (wr_cmp_lo),
        .wr_cmp_hi (wr_cmp_hi),
        .st_clr    (st_clr),
        .bus_rdata (bus_rdata)
    );

    gtt_counter #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctrl.run),
        .wr_lo (wr_cnt_lo),
        .wr_hi (wr_cnt_hi),
        .wdata (bus_wdata),
        .count (count)
    );

    gtt_compare #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_compare (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl),
        .count     (count),
        .step      (step),
        .wr_lo     (wr_cmp_lo),
        .wr_hi     (wr_cmp_hi),
        .wdata     (bus_wdata),
        .cmp_val   (cmp_val),
        .cmp_event (cmp_event),
        .irq       (tick_irq)
    );

endmodule

// File: rtl/gtt_checker.sv
module gtt_checker #(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             cmp_on,
    input logic             cnt_wr,
    input logic             st_clr,
    input logic             pending,
    input logic             irq,
    input logic [CNT_W-1:0] count
);

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (count == $past(count) + 1'b1));

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(count));

    // R10
    no_cmp_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_on |=> !irq);

    // R9
    clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pending) |-> $past(st_clr));

    // R6
    irq_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pending);

endmodule

bind global_tick_timer gtt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl.run),
    .cmp_on  (ctrl.cmp_on),
    .cnt_wr  (wr_cnt_lo || wr_cnt_hi),
    .st_clr  (st_clr),
    .pending (pending),
    .irq     (tick_irq),
    .count   (count)
);

// File: tb/global_tick_timer_test.sv
`timescale 1ns/1ps
module global_tick_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model
    logic [63:0] m_cnt, m_cmp;
    logic [3:0]  m_ctl;
    logic [31:0] m_step;
    logic        m_pend, m_irq;
    int          m_arm;   // 0 off, 1 armed, 2 fired

    always #2 clk = ~clk;

    global_tick_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .tick_irq(tick_irq)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: return {28'd0, m_ctl};
            3'd1: return m_cnt[31:0];
            3'd2: return m_cnt[63:32];
            3'd3: return m_cmp[31:0];
            3'd4: return m_cmp[63:32];
            3'd5: return m_step;
            3'd6: return {31'd0, m_pend};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0: return "R4";
            3'd1, 3'd2: return "R3";
            3'd3, 3'd4, 3'd5: return "R7";
            3'd6: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic model_reset();
        m_cnt = '0; m_cmp = '0; m_ctl = '0; m_step = '0;
        m_pend = 1'b0; m_irq = 1'b0; m_arm = 0;
    endtask

    task automatic model_edge(input bit en, input bit we, input logic [2:0] a, input logic [31:0] d);
        bit          evt, wr, cw;
        logic [63:0] n_cnt, n_cmp;
        int          n_arm;
        evt = (m_arm == 1) && m_ctl[1] && (m_cnt >= m_cmp);
        wr  = en && we;
        cw  = wr && (a == 3'd3 || a == 3'd4);
        n_cnt = m_cnt;
        if (wr && a == 3'd1 && !m_ctl[0]) n_cnt[31:0] = d;
        else if (wr && a == 3'd2 && !m_ctl[0]) n_cnt[63:32] = d;
        else if (m_ctl[0]) n_cnt = m_cnt + 64'd1;
        n_cmp = m_cmp;
        if (wr && a == 3'd3) n_cmp[31:0] = d;
        else if (wr && a == 3'd4) n_cmp[63:32] = d;
        else if (evt && m_ctl[3]) n_cmp = m_cmp + {32'd0, m_step};
        if (!m_ctl[1]) n_arm = 0;
        else if (cw) n_arm = 1;
        else if (m_arm == 0) n_arm = 1;
        else if (m_arm == 1 && evt && !m_ctl[3]) n_arm = 2;
        else n_arm = m_arm;
        if (evt) m_pend = 1'b1;
        else if (wr && a == 3'd6 && d[0]) m_pend = 1'b0;
        m_irq = evt && m_ctl[2];
        if (wr && a == 3'd0) m_ctl = d[3:0];
        if (wr && a == 3'd5) m_step = d;
        m_cnt = n_cnt; m_cmp = n_cmp; m_arm = n_arm;
    endtask

    // one bus cycle; a read is checked before the edge, irq after it
    task automatic cyc(input bit en, input bit we, input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d;
        #1;
        if (en && !we)
            check(bus_rdata == exp_read(a), tag_of(a), {32'd0, bus_rdata}, {32'd0, exp_read(a)});
        @(posedge clk);
        model_edge(en, we, a, d);
        #1;
        check(tick_irq == m_irq, "R6", {63'd0, tick_irq}, {63'd0, m_irq});
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        cyc(1'b1, 1'b1, a, d);
    endtask

    task automatic rd(input logic [2:0] a);
        cyc(1'b1, 1'b0, a, 32'd0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 3'd0, 32'd0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int irq_seen;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state of every register
        for (int a = 0; a < 8; a++) rd(3'(a));
        check(tick_irq == 1'b0, "R1", {63'd0, tick_irq}, 64'd0);

        // R3: load counter while stopped, R2: carry into high word
        wr(3'd1, 32'hFFFF_FFF0);
        wr(3'd2, 32'h0000_0001);
        rd(3'd1); rd(3'd2);
        wr(3'd0, 32'hFFFF_FFF1);      // R4: only low four bits kept
        rd(3'd0);
        idle(20);
        rd(3'd2); rd(3'd1); rd(3'd2);
        check(m_cnt[63:32] == 32'd2, "R2", m_cnt, 64'h2_0000_0000);
        // R3: writes ignored while running
        wr(3'd1, 32'h1234_5678);
        rd(3'd1);
        wr(3'd0, 32'd0);
        idle(3);
        rd(3'd1);                     // R2: holds when stopped

        // R5/R6/R7: periodic ticks in step mode
        wr(3'd1, 32'd100); wr(3'd2, 32'd0);
        wr(3'd3, 32'd110); wr(3'd4, 32'd0);
        wr(3'd5, 32'd7);
        wr(3'd0, 32'hF);
        irq_seen = 0;
        for (int i = 0; i < 40; i++) begin
            idle(1);
            if (tick_irq) irq_seen++;
        end
        check(irq_seen >= 5, "R7", 64'(irq_seen), 64'd5);
        rd(3'd6); rd(3'd3);
        check(m_pend == 1'b1, "R5", {63'd0, m_pend}, 64'd1);

        // R9: clear colliding with an event every cycle (step 0)
        wr(3'd5, 32'd0);
        idle(2);
        wr(3'd6, 32'd1);
        rd(3'd6);
        // R8: one-shot with interrupts off
        wr(3'd0, 32'h1);
        wr(3'd6, 32'd0);              // R9: writing 0 has no effect
        rd(3'd6);
        wr(3'd6, 32'd1);
        rd(3'd6);
        wr(3'd0, 32'h3);
        idle(4);
        rd(3'd6);
        check(m_pend == 1'b1 && m_arm == 2, "R8", {63'd0, m_pend}, 64'd1);
        wr(3'd6, 32'd1);
        idle(5);
        rd(3'd6);                     // R8: no second event
        wr(3'd3, m_cnt[31:0] + 32'd3); // R8: rearm by compare write
        idle(6);
        rd(3'd6);

        // random phase: R10 write priority and general mix
        for (int i = 0; i < 4000; i++) begin
            logic [2:0]  a;
            logic [31:0] d;
            bit          en, we;
            a  = 3'($urandom_range(0, 7));
            en = ($urandom_range(0, 3) != 0);
            we = ($urandom_range(0, 2) == 0);
            d  = $urandom();
            if (a == 3'd0) d = {28'd0, 4'($urandom_range(0, 15))};
            if (a == 3'd3) d = m_cnt[31:0] + 32'($urandom_range(0, 40));
            if (a == 3'd4) d = m_cnt[63:32];
            if (a == 3'd5) d = 32'($urandom_range(0, 12));
            if (a == 3'd2 && $urandom_range(0, 1) == 0) d = m_cmp[63:32];
            cyc(en, we, a, d);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule